// File: doc/BRIEF.md
# Host Serial Byte Buffer with Hysteresis Stop Signal

This block sits between a host serial port and a packet link. Bytes arriving from the host are held in a receive queue until a packet consumer drains them. A registered stop signal tells the host to pause before that queue fills. The stop signal turns on once free space falls to a low mark and turns off only after free space has climbed back to a higher mark. This gap keeps the signal from toggling on every byte.

Toward the host, a transmit queue accepts packets from the link side and streams their bytes out. Each packet is announced by its length before its first byte. At that moment the block compares the length with the free space in the transmit queue. A packet that fits is stored in full. A packet that does not fit has all of its bytes accepted and thrown away, and a drop counter advances. A packet is therefore never stored in part.

Both queues are 128 bytes deep by default, and the two thresholds are parameters. A byte from the host that finds the receive queue full is lost and raises a sticky overflow flag.

Top module: `hostlink_buffer`

## Requirements
- R1: Host bytes are delivered on the receive drain port in arrival order; `rxq_valid` is high exactly when the receive queue holds at least one byte, and a byte leaves when `rxq_valid` and `rxq_ready` are both high at a clock edge.
- R2: With `fc_en` high, `cts_o` goes high (stop) on the clock edge after the receive queue's free space becomes 17 bytes or fewer; with 18 free it stays low.
- R3: Once high, `cts_o` stays high while free space is between 18 and 33 bytes, and returns low on the edge after free space reaches 34 or more.
- R4: With `fc_en` low, `cts_o` is low on the edge after, whatever the fill level.
- R5: A host byte presented while the receive queue holds 128 bytes is discarded, and `overflow_o` goes high and stays high until reset.
- R6: A packet whose length is no larger than the transmit queue's free space when its length is accepted is stored whole, including an exact fit, and its bytes reach the host port in order.
- R7: A packet whose length exceeds that free space has every byte accepted on `pkt_byte_ready` and none stored, and `drop_count` rises by one.
- R8: A length is accepted only while no packet is in progress (`pkt_len_ready` high); a length of zero is taken as an empty packet and changes neither queue nor `drop_count`.
- R9: Reset empties both queues, drives `cts_o` low and clears `overflow_o` and `drop_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fc_en | input | 1 | Enables stop-signal flow control |
| h2l_valid | input | 1 | A host byte is present this cycle |
| h2l_data | input | 8 | Host byte |
| rxq_valid | output | 1 | Receive queue not empty |
| rxq_data | output | 8 | Oldest byte in the receive queue |
| rxq_ready | input | 1 | Consumer takes the oldest byte |
| cts_o | output | 1 | High: host must pause sending |
| overflow_o | output | 1 | Sticky: a host byte was lost |
| pkt_len_valid | input | 1 | Packet length offered |
| pkt_len | input | 8 | Packet length in bytes |
| pkt_len_ready | output | 1 | Block is between packets and takes the length |
| pkt_byte_valid | input | 1 | Packet byte offered |
| pkt_byte_data | input | 8 | Packet byte |
| pkt_byte_ready | output | 1 | Block takes a packet byte (stored or discarded) |
| txh_valid | output | 1 | Transmit queue not empty |
| txh_data | output | 8 | Next byte toward the host |
| txh_ready | input | 1 | Host side takes the byte |
| drop_count | output | 16 | Number of packets dropped, wrapping |

## Verification
The assertions assume that the link side never offers more bytes than the length it announced and never offers bytes outside a packet. They also assume that `fc_en` is a slow configuration input. The bench drives each packet through a task that sends exactly the announced number of bytes, and it changes `fc_en` only while the host and drain inputs are idle. The threshold assertions then compare free space in one cycle with `cts_o` in the next, which is valid because free space changes only through host pushes and drain pops.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  typedef enum logic [1:0] {
    ADM_IDLE = 2'd0,
    ADM_PASS = 2'd1,
    ADM_DROP = 2'd2
  } adm_state_t;
endpackage

// File: rtl/hlb_byte_fifo.sv
module hlb_byte_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_nx, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] count_nx;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    if (do_push) wr_ptr_nx = wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_nx = rd_ptr + 1'b1;
    case ({do_push, do_pop})
      2'b10:   count_nx = count + 1'b1;
      2'b01:   count_nx = count - 1'b1;
      default: count_nx = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/hlb_cts_ctrl.sv
module hlb_cts_ctrl #(
  parameter int DEPTH       = 128,
  parameter int STOP_FREE   = 17,
  parameter int RESUME_FREE = 34,
  localparam int CW         = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] free_slots,
  output logic          stop
);
  localparam logic [CW-1:0] STOP_C   = CW'(STOP_FREE);
  localparam logic [CW-1:0] RESUME_C = CW'(RESUME_FREE);

  logic stop_nx;

  always_comb begin
    stop_nx = stop;
    if (!en)                          stop_nx = 1'b0;
    else if (free_slots <= STOP_C)    stop_nx = 1'b1;
    else if (free_slots >= RESUME_C)  stop_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop <= 1'b0;
    else        stop <= stop_nx;
  end
endmodule

// File: rtl/hlb_pkt_admit.sv
module hlb_pkt_admit
  import hlb_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 16,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len,
  output logic             len_ready,
  input  logic             byte_valid,
  input  logic [W-1:0]     byte_data,
  output logic             byte_ready,
  input  logic [LEN_W-1:0] tx_free,
  output logic             push,
  output logic [W-1:0]     push_data,
  output logic [CNT_W-1:0] drop_count
);
  adm_state_t       st, st_nx;
  logic [LEN_W-1:0] rem, rem_nx;
  logic [CNT_W-1:0] drop_nx;

  assign len_ready  = (st == ADM_IDLE);
  assign byte_ready = (st != ADM_IDLE);
  assign push       = (st == ADM_PASS) && byte_valid;
  assign push_data  = byte_data;

  always_comb begin
    st_nx   = st;
    rem_nx  = rem;
    drop_nx = drop_count;
    case (st)
      ADM_IDLE: begin
        if (len_valid && (len != '0)) begin
          rem_nx = len;
          if (len <= tx_free) begin
            st_nx = ADM_PASS;
          end else begin
            st_nx   = ADM_DROP;
            drop_nx = drop_count + 1'b1;
          end
        end
      end
      ADM_PASS, ADM_DROP: begin
        if (byte_valid) begin
          rem_nx = rem - 1'b1;
          if (rem == LEN_W'(1)) st_nx = ADM_IDLE;
        end
      end
      default: st_nx = ADM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ADM_IDLE;
      rem        <= '0;
      drop_count <= '0;
    end else begin
      st         <= st_nx;
      rem        <= rem_nx;
      drop_count <= drop_nx;
    end
  end
endmodule

// File: rtl/hostlink_buffer.sv
module hostlink_buffer #(
  parameter int DEPTH       = 128,
  parameter int STOP_FREE   = 17,
  parameter int RESUME_FREE = 34,
  parameter int CNT_W       = 16,
  localparam int LEN_W      = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_en,
  input  logic             h2l_valid,
  input  logic [7:0]       h2l_data,
  output logic             rxq_valid,
  output logic [7:0]       rxq_data,
  input  logic             rxq_ready,
  output logic             cts_o,
  output logic             overflow_o,
  input  logic             pkt_len_valid,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             pkt_len_ready,
  input  logic             pkt_byte_valid,
  input  logic [7:0]       pkt_byte_data,
  output logic             pkt_byte_ready,
  output logic             txh_valid,
  output logic [7:0]       txh_data,
  input  logic             txh_ready,
  output logic [CNT_W-1:0] drop_count
);
  localparam logic [LEN_W-1:0] DEPTH_C = LEN_W'(DEPTH);

  // reset: asserted at once, released after two clock edges
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // host -> link receive path
  logic [LEN_W-1:0] rx_count, rx_free;
  logic             rx_empty, rx_full, rx_push, rx_lost;
  logic             ovf_nx;

  assign rx_push   = h2l_valid && !rx_full;
  assign rx_lost   = h2l_valid && rx_full;
  assign rx_free   = DEPTH_C - rx_count;
  assign rxq_valid = !rx_empty;

  hlb_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_q_n),
    .push  (rx_push),
    .wdata (h2l_data),
    .pop   (rxq_ready),
    .rdata (rxq_data),
    .count (rx_count),
    .empty (rx_empty),
    .full  (rx_full)
  );

  hlb_cts_ctrl #(
    .DEPTH(DEPTH), .STOP_FREE(STOP_FREE), .RESUME_FREE(RESUME_FREE)
  ) u_cts (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en         (fc_en),
    .free_slots (rx_free),
    .stop       (cts_o)
  );

  always_comb ovf_nx = overflow_o || rx_lost;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) overflow_o <= 1'b0;
    else          overflow_o <= ovf_nx;
  end

  // link -> host transmit path
  logic [LEN_W-1:0] tx_count, tx_free;
  logic             tx_empty, tx_full, tx_push;
  logic [7:0]       tx_wdata;

  assign tx_free   = DEPTH_C - tx_count;
  assign txh_valid = !tx_empty;

  hlb_pkt_admit #(.LEN_W(LEN_W), .CNT_W(CNT_W), .W(8)) u_admit (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .len_valid  (pkt_len_valid),
    .len        (pkt_len),
    .len_ready  (pkt_len_ready),
    .byte_valid (pkt_byte_valid),
    .byte_data  (pkt_byte_data),
    .byte_ready (pkt_byte_ready),
    .tx_free    (tx_free),
    .push       (tx_push),
    .push_data  (tx_wdata),
    .drop_count (drop_count)
  );

  hlb_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_q_n),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (txh_ready),
    .rdata (txh_data),
    .count (tx_count),
    .empty (tx_empty),
    .full  (tx_full)
  );

  // a packet is only admitted when it fits, so the queue never refuses a push
  logic unused_tx_full;
  assign unused_tx_full = tx_full;
endmodule

// File: rtl/hostlink_buffer_chk.sv
module hostlink_buffer_chk #(
  parameter int DEPTH       = 128,
  parameter int STOP_FREE   = 17,
  parameter int RESUME_FREE = 34,
  parameter int CNT_W       = 16,
  localparam int LEN_W      = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             fc_en,
  input logic             h2l_valid,
  input logic             cts_o,
  input logic             overflow_o,
  input logic [LEN_W-1:0] rx_free,
  input logic [LEN_W-1:0] tx_free,
  input logic             pkt_len_valid,
  input logic             pkt_len_ready,
  input logic [LEN_W-1:0] pkt_len,
  input logic [CNT_W-1:0] drop_count
);
  a_r2_stop_at_low_mark: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fc_en && rx_free <= LEN_W'(STOP_FREE)) |=> cts_o);

  a_r3_release_at_high_mark: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fc_en && rx_free >= LEN_W'(RESUME_FREE)) |=> !cts_o);

  a_r3_hold_in_band: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fc_en && rx_free > LEN_W'(STOP_FREE) && rx_free < LEN_W'(RESUME_FREE))
      |=> (cts_o == $past(cts_o)));

  a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fc_en |=> !cts_o);

  a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_q_n)
    (h2l_valid && rx_free == '0) |=> overflow_o);

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    overflow_o |=> overflow_o);

  a_r7_drop_counted: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pkt_len_valid && pkt_len_ready && pkt_len > tx_free)
      |=> (drop_count == $past(drop_count) + 1'b1));

  a_r6_admit_not_counted: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pkt_len_valid && pkt_len_ready && pkt_len <= tx_free) |=> $stable(drop_count));

  a_r1_free_in_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_free <= LEN_W'(DEPTH));
endmodule

bind hostlink_buffer hostlink_buffer_chk #(
  .DEPTH(DEPTH), .STOP_FREE(STOP_FREE), .RESUME_FREE(RESUME_FREE), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .fc_en         (fc_en),
  .h2l_valid     (h2l_valid),
  .cts_o         (cts_o),
  .overflow_o    (overflow_o),
  .rx_free       (rx_free),
  .tx_free       (tx_free),
  .pkt_len_valid (pkt_len_valid),
  .pkt_len_ready (pkt_len_ready),
  .pkt_len       (pkt_len),
  .drop_count    (drop_count)
);

// File: tb/hostlink_buffer_tb.sv
`timescale 1ns/1ps
module hostlink_buffer_tb;
  localparam int DEPTH = 128;
  localparam int NV    = 4;
  // packet-side vectors: length offered, expected cumulative drop count
  localparam int VLEN  [NV] = '{100, 30, 28, 1};
  localparam int VDROP [NV] = '{0, 1, 1, 2};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, fc_en, h2l_valid, rxq_ready;
  logic [7:0]  h2l_data;
  logic        rxq_valid, cts_o, overflow_o;
  logic [7:0]  rxq_data;
  logic        pkt_len_valid, pkt_len_ready, pkt_byte_valid, pkt_byte_ready;
  logic [7:0]  pkt_len, pkt_byte_data;
  logic        txh_valid, txh_ready;
  logic [7:0]  txh_data;
  logic [15:0] drop_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] rx_exp [$];
  logic [7:0] tx_exp [$];

  hostlink_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en),
    .h2l_valid(h2l_valid), .h2l_data(h2l_data),
    .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_ready(rxq_ready),
    .cts_o(cts_o), .overflow_o(overflow_o),
    .pkt_len_valid(pkt_len_valid), .pkt_len(pkt_len), .pkt_len_ready(pkt_len_ready),
    .pkt_byte_valid(pkt_byte_valid), .pkt_byte_data(pkt_byte_data),
    .pkt_byte_ready(pkt_byte_ready),
    .txh_valid(txh_valid), .txh_data(txh_data), .txh_ready(txh_ready),
    .drop_count(drop_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fc_en = 1'b1; h2l_valid = 1'b0; h2l_data = '0; rxq_ready = 1'b0;
    pkt_len_valid = 1'b0; pkt_len = '0; pkt_byte_valid = 1'b0; pkt_byte_data = '0;
    txh_ready = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rx_exp.delete();
    tx_exp.delete();
  endtask

  task automatic host_push(input logic [7:0] d, input bit accept);
    h2l_valid = 1'b1; h2l_data = d;
    @(negedge clk);
    h2l_valid = 1'b0;
    if (accept) rx_exp.push_back(d);
  endtask

  task automatic rx_pop();
    logic [7:0] e;
    check("R1 rxq_valid before pop", int'(rxq_valid), 1);
    e = rx_exp.pop_front();
    check("R1 rx byte order", int'(rxq_data), int'(e));
    rxq_ready = 1'b1;
    @(negedge clk);
    rxq_ready = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int tag, input bit store);
    check("R8 length ready when idle", int'(pkt_len_ready), 1);
    pkt_len_valid = 1'b1; pkt_len = 8'(len);
    @(negedge clk);
    pkt_len_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      pkt_byte_valid = 1'b1;
      pkt_byte_data  = 8'(tag * 37 + i);
      check("R7 byte taken in packet", int'(pkt_byte_ready), 1);
      if (store) tx_exp.push_back(pkt_byte_data);
      @(negedge clk);
    end
    pkt_byte_valid = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    check("R9 cts low", int'(cts_o), 0);
    check("R9 overflow clear", int'(overflow_o), 0);
    check("R9 rx empty", int'(rxq_valid), 0);
    check("R9 tx empty", int'(txh_valid), 0);
    check("R9 drop zero", int'(drop_count), 0);

    // packet admission vectors, host side holds off draining
    for (int v = 0; v < NV; v++) begin
      send_pkt(VLEN[v], v, (v == 0) || (v == 2));
      idle(1);
      check($sformatf("R6/R7 drop count after vector %0d", v), int'(drop_count), VDROP[v]);
    end
    // R8 zero length: no drop, no bytes
    pkt_len_valid = 1'b1; pkt_len = 8'd0;
    @(negedge clk);
    pkt_len_valid = 1'b0;
    check("R8 zero length leaves drop count", int'(drop_count), 2);
    check("R8 zero length keeps length ready", int'(pkt_len_ready), 1);
    // drain toward host: packets 0 and 2 only, in order (R6, R7)
    begin
      int n = 0;
      while (txh_valid && n < 200) begin
        logic [7:0] e;
        e = tx_exp.pop_front();
        check("R6 tx byte order", int'(txh_data), int'(e));
        txh_ready = 1'b1;
        @(negedge clk);
        txh_ready = 1'b0;
        n++;
      end
      check("R7 stored byte total", n, 128);
    end

    // receive path and flow control
    for (int i = 0; i < 110; i++) host_push(8'(i) ^ 8'h5A, 1'b1);
    idle(2);
    check("R2 18 free keeps cts low", int'(cts_o), 0);
    host_push(8'd110 ^ 8'h5A, 1'b1);
    idle(2);
    check("R2 17 free raises cts", int'(cts_o), 1);
    for (int i = 0; i < 16; i++) rx_pop();
    idle(2);
    check("R3 33 free keeps cts high", int'(cts_o), 1);
    rx_pop();
    idle(2);
    check("R3 34 free drops cts", int'(cts_o), 0);
    for (int i = 0; i < 34; i++) host_push(8'(i + 111) ^ 8'h5A, 1'b1);
    idle(2);
    check("R5 full without loss", int'(overflow_o), 0);
    check("R2 full raises cts", int'(cts_o), 1);
    host_push(8'hEE, 1'b0);
    idle(1);
    check("R5 overflow set", int'(overflow_o), 1);
    fc_en = 1'b0;
    idle(2);
    check("R4 disabled forces cts low", int'(cts_o), 0);
    fc_en = 1'b1;
    idle(2);
    check("R4 re-enable restores stop", int'(cts_o), 1);
    for (int i = 0; i < 128; i++) rx_pop();
    check("R5 lost byte not stored", int'(rxq_valid), 0);
    check("R5 overflow sticky", int'(overflow_o), 1);

    do_reset();
    check("R9 overflow cleared", int'(overflow_o), 0);
    check("R9 drop cleared", int'(drop_count), 0);
    check("R9 cts low after reset", int'(cts_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule